// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block sits between a serial deserializer and the host-facing register logic of a 16550-style UART. It takes each received byte, or a break event, from the deserializer and stores it in a 16-entry first-in-first-out queue. The host pops bytes by reading the data register. A trigger level is selected by a write to the FIFO control register. The block reports when the queue holds at least that many bytes. A character timeout detector flags data that has sat unread for four character times.

The character time comes from the line control register and is counted on a one-per-bit-time tick. When the queue is switched off, the block falls back to a single holding byte: a new byte overwrites it, and an overrun is flagged if the old byte was unread. Serial deserialization and the encoding of the interrupt identity are handled by neighbouring blocks.

Top module: `uart_rx_queue`

## Requirements
- R1: In queue mode, FIFO control bits 7:6 select the trigger level (00 gives 1 byte, 01 gives 4, 10 gives 8, 11 gives 14). `trig_hit` is high when the stored count is at least that level.
- R2: Bytes leave in arrival order. `dout` shows the oldest stored byte. A data read while the queue is empty returns 0.
- R3: When the queue holds 16 bytes and no read happens in the same cycle, an arriving byte is discarded. The stored bytes are kept and `overrun` is set.
- R4: A break event stores a 0x00 byte and sets both `brk_flag` and `data_ready`.
- R5: A data read that leaves no data behind clears `data_ready` and `brk_flag`.
- R6: In queue mode, every arrival, and every data read that leaves data behind, restarts a count of 4 character times in bit ticks. If data is still stored when the count runs out, `tmo_pending` is set. Any data read clears it.
- R7: The character time in bits is 1 start bit, plus (`line_ctrl[1:0]` + 5) data bits, plus 1 bit when `line_ctrl[3]` is set, plus 2 stop bits when `line_ctrl[2]` is set (otherwise 1).
- R8: A FIFO control write with bit 1 set empties the receive storage and clears `data_ready`, `brk_flag` and `tmo_pending`. A write whose bit 0 differs from the current enable forces the same clearing. Bit 0 set selects queue mode.
- R9: A line status read strobe clears `brk_flag` and `overrun`, unless a new event sets them in the same cycle.
- R10: In holding mode, one byte is kept. A new byte overwrites it, and it sets `overrun` if `data_ready` was already set and no read occurs in that cycle. `trig_hit` then follows `data_ready`.
- R11: After reset, the block is in holding mode with a holding byte of 0x00 and trigger level 1. All flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Deserializer delivers `rx_data` this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Deserializer reports a break this cycle |
| cfg_wr | input | 1 | FIFO control register write strobe |
| cfg_data | input | 8 | FIFO control write value |
| rd_data | input | 1 | Host data register read strobe (pops one byte) |
| rd_lsr | input | 1 | Host line status read strobe |
| line_ctrl | input | 8 | Line control register value |
| bit_tick | input | 1 | One pulse per serial bit time |
| dout | output | 8 | Byte a data read returns this cycle |
| data_ready | output | 1 | Received data is available |
| overrun | output | 1 | A byte was lost or overwritten |
| brk_flag | output | 1 | A break was received |
| trig_hit | output | 1 | Trigger level reached |
| tmo_pending | output | 1 | Character timeout pending |

## Verification
The bench fills the queue to exactly 16 bytes and then offers a 17th. A design that overwrote or shifted stored data would return wrong bytes on the drain that follows. The timeout is probed one tick before and one tick on its limit, for two frame formats. An off-by-one counter, or a frame length that ignored parity or the second stop bit, shows up as a flag in the wrong cycle. The bench also shows that a read leaving data behind rearms the timeout, and that toggling the enable bit flushes stored data even with the reset bit clear. Holding mode is exercised for overwrite and overrun, and a break is shown to read back as a zero byte.

// File: rtl/uart_rxq_pkg.sv
// Package: shared helpers for the receive queue.
// Assumes a line control byte with word length in bits 1:0,
// stop-bit count in bit 2 and parity enable in bit 3.
package uart_rxq_pkg;

    localparam int LVL_W   = 5;
    localparam int FRAME_W = 4;

    // Map the two trigger-select bits onto a byte count.
    function automatic logic [LVL_W-1:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   trig_level = LVL_W'(1);
            2'b01:   trig_level = LVL_W'(4);
            2'b10:   trig_level = LVL_W'(8);
            default: trig_level = LVL_W'(14);
        endcase
    endfunction

    // Bits per character: start + data + optional parity + stop.
    function automatic logic [FRAME_W-1:0] frame_bits(input logic [3:0] lc);
        frame_bits = FRAME_W'(1) + FRAME_W'(lc[1:0]) + FRAME_W'(5)
                   + FRAME_W'(lc[3]) + (lc[2] ? FRAME_W'(2) : FRAME_W'(1));
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
// Module: FIFO control register decode.
// Holds the queue enable and trigger level. Issues a one-cycle clear
// when the receive-reset bit is written or the enable bit changes.
module rxq_ctrl
    import uart_rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_data,
    output logic             fifo_en,
    output logic [LVL_W-1:0] level,
    output logic             clr
);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_data[5:2];

    // Clear pulse: explicit receive reset or an enable change.
    assign clr = cfg_wr && (cfg_data[1] || (cfg_data[0] != fifo_en));

    // Register the enable and the decoded trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            level   <= LVL_W'(1);
        end else if (cfg_wr) begin
            fifo_en <= cfg_data[0];
            level   <= trig_level(cfg_data[7:6]);
        end
    end

endmodule

// File: rtl/rxq_store.sv
// Module: circular byte storage with occupancy count.
// Assumes the caller never writes when full unless it pops in the same
// cycle, and never pops when empty. A clear overrides both.
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // Write the incoming byte into its slot.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance pointers and track the number of stored bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    // R3: occupancy never exceeds the storage depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CNT_W'(DEPTH)));

endmodule

// File: rtl/rxq_timer.sv
// Module: character timeout detector.
// Counts bit ticks while armed. Expires after `limit` ticks, and sets the
// pending flag if data is still stored at that point. Assumes limit >= 1.
module rxq_timer #(
    parameter int MAX_LIMIT = 48,
    localparam int CNT_W = $clog2(MAX_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             stop,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic             has_data,
    input  logic             clr_pend,
    output logic             pending
);

    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             expire;

    assign expire = armed && tick && !restart && !stop && (cnt == limit - 1'b1);

    // Arm, count ticks and disarm on expiry or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (stop || expire) begin
            armed <= 1'b0;
        end else if (armed && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Timeout-pending flag: set on expiry with data, cleared by a read or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_pend) begin
            pending <= 1'b0;
        end else if (expire && has_data) begin
            pending <= 1'b1;
        end
    end

    // R6: the flag only rises when data was present.
    p_tmo_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(has_data));

endmodule

// File: rtl/uart_rx_queue.sv
// Module: receive queue top level.
// Combines control decode, storage, timeout and status flags.
// Assumes one received event per cycle at most, and that the host read
// strobes are single-cycle pulses.
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int TMR_MAX  = TMO_CHARS * 12,
    localparam int TMR_W    = $clog2(TMR_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_break,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_data,
    input  logic       rd_data,
    input  logic       rd_lsr,
    input  logic [7:0] line_ctrl,
    input  logic       bit_tick,
    output logic [7:0] dout,
    output logic       data_ready,
    output logic       overrun,
    output logic       brk_flag,
    output logic       trig_hit,
    output logic       tmo_pending
);

    logic             fifo_en;
    logic [LVL_W-1:0] level;
    logic             clr;
    logic [7:0]       head;
    logic [CNT_W-1:0] count;
    logic             empty;
    logic             full;
    logic [7:0]       hold_byte;
    logic             hold_valid;
    logic             push_any;
    logic [7:0]       push_byte;
    logic             pop;
    logic             full_block;
    logic             wr_en;
    logic [CNT_W-1:0] cnt_after_rd;
    logic             leaves_empty;
    logic             ovr_set;
    logic             tmr_restart;
    logic             tmr_stop;
    logic [TMR_W-1:0] tmr_limit;
    logic [3:0]       unused_lc;

    assign unused_lc = line_ctrl[7:4];

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .fifo_en  (fifo_en),
        .level    (level),
        .clr      (clr)
    );

    // Arrival and pop qualification.
    assign push_any     = rx_valid || rx_break;
    assign push_byte    = rx_break ? 8'h00 : rx_data;
    assign pop          = fifo_en && rd_data && !empty && !clr;
    assign full_block   = full && !pop;
    assign wr_en        = fifo_en && push_any && !clr && !full_block;
    assign cnt_after_rd = count - CNT_W'(pop);
    assign leaves_empty = rd_data && (fifo_en ? (cnt_after_rd == '0 && !wr_en) : !push_any);

    rxq_store #(.DEPTH(DEPTH), .DATA_W(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_data (push_byte),
        .rd_en   (pop),
        .head    (head),
        .count   (count),
        .empty   (empty),
        .full    (full)
    );

    // Timeout control: rearm on arrival or a read that leaves data.
    assign tmr_restart = fifo_en && !clr && (push_any || (rd_data && cnt_after_rd != '0));
    assign tmr_stop    = clr || !fifo_en || rd_data;
    assign tmr_limit   = TMR_W'(TMO_CHARS) * TMR_W'(frame_bits(line_ctrl[3:0]));

    rxq_timer #(.MAX_LIMIT(TMR_MAX)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (tmr_restart),
        .stop     (tmr_stop),
        .tick     (bit_tick),
        .limit    (tmr_limit),
        .has_data (!empty),
        .clr_pend (clr || (fifo_en && rd_data)),
        .pending  (tmo_pending)
    );

    // Holding register used when the queue is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_byte  <= 8'h00;
            hold_valid <= 1'b0;
        end else if (clr) begin
            hold_valid <= 1'b0;
        end else if (!fifo_en) begin
            if (push_any) begin
                hold_byte  <= push_byte;
                hold_valid <= 1'b1;
            end else if (rd_data) begin
                hold_valid <= 1'b0;
            end
        end
    end

    // Overrun flag: lost byte in queue mode, overwrite in holding mode.
    assign ovr_set = push_any && !clr && (fifo_en ? full_block : (hold_valid && !rd_data));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (ovr_set) begin
            overrun <= 1'b1;
        end else if (rd_lsr) begin
            overrun <= 1'b0;
        end
    end

    // Break flag: set by a break, cleared by flush, status read or draining read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_flag <= 1'b0;
        end else if (rx_break && !clr) begin
            brk_flag <= 1'b1;
        end else if (clr || rd_lsr || leaves_empty) begin
            brk_flag <= 1'b0;
        end
    end

    // Outputs seen by the host side.
    assign data_ready = fifo_en ? !empty : hold_valid;
    assign dout       = fifo_en ? (empty ? 8'h00 : head) : hold_byte;
    assign trig_hit   = data_ready && (!fifo_en || count >= CNT_W'(level));

    // R3: a full queue keeps its contents and flags the lost byte.
    p_full_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && full && push_any && !rd_data && !clr) |=> (overrun && $stable(count)));

    // R4: a break leaves both the break and data-ready flags set.
    p_brk_dr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !clr) |=> (brk_flag && data_ready));

    // R8: a flush leaves nothing ready and no timeout pending.
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!data_ready && !tmo_pending && !brk_flag));

    // R9: a status read with no new event clears break and overrun.
    p_lsr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !push_any) |=> (!overrun && !brk_flag));

endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    // Vector: {op[2:0], arg[7:0], exp_dout[7:0], flags[4:0]}
    // op 0 push, 1 data read, 2 status read, 3 control write, 4 break
    // flags = {data_ready, overrun, brk_flag, trig_hit, tmo_pending}
    localparam logic [23:0] VEC [NVEC] = '{
        {3'd3, 8'h01, 8'h00, 5'b00000},  // R8 enable queue, level 1
        {3'd0, 8'h11, 8'h00, 5'b10010},  // R1 level 1 reached
        {3'd0, 8'h22, 8'h00, 5'b10010},
        {3'd1, 8'h00, 8'h11, 5'b10010},  // R2 order
        {3'd1, 8'h00, 8'h22, 5'b00000},  // R5
        {3'd3, 8'h41, 8'h00, 5'b00000},  // R1 level 4
        {3'd0, 8'hA1, 8'h00, 5'b10000},
        {3'd0, 8'hA2, 8'h00, 5'b10000},
        {3'd0, 8'hA3, 8'h00, 5'b10000},
        {3'd0, 8'hA4, 8'h00, 5'b10010},  // R1 4 bytes
        {3'd4, 8'h00, 8'h00, 5'b10110},  // R4 break
        {3'd2, 8'h00, 8'h00, 5'b10010},  // R9
        {3'd1, 8'h00, 8'hA1, 5'b10010},
        {3'd1, 8'h00, 8'hA2, 5'b10000},
        {3'd1, 8'h00, 8'hA3, 5'b10000},
        {3'd1, 8'h00, 8'hA4, 5'b10000},
        {3'd1, 8'h00, 8'h00, 5'b00000},  // R4 zero byte
        {3'd1, 8'h00, 8'h00, 5'b00000},  // R2 empty read
        {3'd3, 8'h83, 8'h00, 5'b00000},  // R8 level 8 with reset
        {3'd0, 8'h5A, 8'h00, 5'b10000},
        {3'd3, 8'h81, 8'h00, 5'b10000},  // R8 no reset without bit 1
        {3'd3, 8'h00, 8'h00, 5'b00000},  // R8 toggle forces flush
        {3'd0, 8'h37, 8'h00, 5'b10010},  // R10 holding
        {3'd0, 8'h48, 8'h00, 5'b11010},  // R10 overwrite overrun
        {3'd1, 8'h00, 8'h48, 5'b01000},  // R10 newest byte
        {3'd2, 8'h00, 8'h00, 5'b00000}   // R9
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_break = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       rd_data = 1'b0;
    logic       rd_lsr = 1'b0;
    logic [7:0] line_ctrl = 8'h03;
    logic       bit_tick = 1'b0;
    logic [7:0] dout;
    logic       data_ready, overrun, brk_flag, trig_hit, tmo_pending;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .rd_data(rd_data), .rd_lsr(rd_lsr), .line_ctrl(line_ctrl),
        .bit_tick(bit_tick), .dout(dout), .data_ready(data_ready),
        .overrun(overrun), .brk_flag(brk_flag), .trig_hit(trig_hit),
        .tmo_pending(tmo_pending)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [4:0] flags();
        return {data_ready, overrun, brk_flag, trig_hit, tmo_pending};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one operation across one clock edge.
    task automatic do_op(input logic [2:0] op, input logic [7:0] arg, output logic [7:0] seen);
        @(negedge clk);
        case (op)
            3'd0: begin rx_valid = 1'b1; rx_data = arg; end
            3'd1: rd_data = 1'b1;
            3'd2: rd_lsr = 1'b1;
            3'd3: begin cfg_wr = 1'b1; cfg_data = arg; end
            default: rx_break = 1'b1;
        endcase
        #1 seen = dout;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rx_break = 1'b0; rd_data = 1'b0; rd_lsr = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            @(posedge clk);
            #1 bit_tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R11 reset state
        check("R11 flags", {3'b0, flags()}, 8'h00);
        check("R11 dout", dout, 8'h00);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            do_op(VEC[i][23:21], VEC[i][20:13], seen);
            if (VEC[i][23:21] == 3'd1) check("R2 table dout", seen, VEC[i][12:5]);
            check("table flags", {3'b0, flags()}, {3'b0, VEC[i][4:0]});
        end

        // R3 and R1: fill to 16 with level 14, then offer one more
        do_op(3'd3, 8'hC7, seen);
        for (int i = 0; i < 16; i++) begin
            do_op(3'd0, 8'h30 + 8'(i), seen);
            if (i == 12) check("R1 level14 below", {7'b0, trig_hit}, 8'h00);
            if (i == 13) check("R1 level14 reached", {7'b0, trig_hit}, 8'h01);
        end
        check("R3 no overrun at 16", {7'b0, overrun}, 8'h00);
        do_op(3'd0, 8'hEE, seen);
        check("R3 overrun set", {7'b0, overrun}, 8'h01);
        for (int i = 0; i < 16; i++) begin
            do_op(3'd1, 8'h00, seen);
            check("R3 contents kept", seen, 8'h30 + 8'(i));
        end
        check("R5 drained", {7'b0, data_ready}, 8'h00);
        do_op(3'd2, 8'h00, seen);
        check("R9 overrun cleared", {7'b0, overrun}, 8'h00);

        // R6 and R7: 8N1 gives 10 bits, limit 40 ticks
        line_ctrl = 8'h03;
        do_op(3'd0, 8'h77, seen);
        ticks(39);
        check("R7 8N1 before limit", {7'b0, tmo_pending}, 8'h00);
        ticks(1);
        check("R6 8N1 at limit", {7'b0, tmo_pending}, 8'h01);
        do_op(3'd1, 8'h00, seen);
        check("R6 read clears", {7'b0, tmo_pending}, 8'h00);

        // R7: 8 data, parity, 2 stop gives 12 bits, limit 48 ticks
        line_ctrl = 8'h0F;
        do_op(3'd0, 8'h01, seen);
        do_op(3'd0, 8'h02, seen);
        ticks(47);
        check("R7 8E2 before limit", {7'b0, tmo_pending}, 8'h00);
        ticks(1);
        check("R7 8E2 at limit", {7'b0, tmo_pending}, 8'h01);
        do_op(3'd1, 8'h00, seen);
        check("R6 read clears again", {7'b0, tmo_pending}, 8'h00);
        ticks(47);
        check("R6 rearm before limit", {7'b0, tmo_pending}, 8'h00);
        ticks(1);
        check("R6 rearmed by read", {7'b0, tmo_pending}, 8'h01);
        do_op(3'd3, 8'hC3, seen);
        check("R8 reset clears", {3'b0, flags()}, 8'h00);

        // R8: toggle enable flushes stored data
        do_op(3'd0, 8'h99, seen);
        do_op(3'd3, 8'h00, seen);
        check("R8 toggle flush", {7'b0, data_ready}, 8'h00);

        // R4 in holding mode: break reads back as zero
        do_op(3'd0, 8'hFF, seen);
        do_op(3'd1, 8'h00, seen);
        do_op(3'd4, 8'h00, seen);
        check("R4 hold flags", {3'b0, flags()}, 8'b000_10110);
        do_op(3'd1, 8'h00, seen);
        check("R4 hold zero byte", seen, 8'h00);
        check("R5 hold read clears", {3'b0, flags()}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule